// File: doc/BRIEF.md
# Power-On Strap Capture Controller

This block decides the clock configuration of a clock generator from five pins that do two jobs. While the device comes out of power-on reset the pins are inputs: four carry a frequency-select code and one selects the rate of the peripheral clock. A timer running on the reference clock counts out the power-up window. When it expires, the block latches the pin values once. One cycle later it releases the output enables, so the same pins can drive clocks.

The latched 4-bit code is decoded into a frequency plan. The plan gives the CPU, memory, mid-rate (66-MHz class), PCI and APIC clock targets, in units of 10 kHz. One code is reserved. If that code is captured, a flag is raised and the plan falls back to the 100.2/100.2 MHz entry. The latched rate strap chooses a 24 MHz peripheral clock when HIGH and a 48 MHz one when LOW. Everything stays fixed until the next power-on reset.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While rst_n is low, and until capture, captured_o is 0, pin_oe_o is all zeros, fs_latched_o, rate_24m_o, plan_idx_o and reserved_o are 0, and every frequency output is 0.
- R2: Capture happens on the TERM_CYCLES-th rising edge of clk_ref after rst_n rises. captured_o goes to 1 on that edge and stays 1 until the next reset.
- R3: After capture, fs_latched_o, rate_24m_o and all plan outputs keep their values whatever the strap inputs do.
- R4: All five bits of pin_oe_o rise together on the edge after capture and never before. Bits 0 to 3 are the select pins 0 to 3; bit 4 is the rate pin.
- R5: rate_24m_o is 1 (24 MHz peripheral clock) when the rate strap was captured HIGH, and 0 (48 MHz) when it was captured LOW.
- R6: cpu_f_o, mem_f_o and mid_f_o follow the 16-entry plan table for the captured code (units of 10 kHz, e.g. code 4'b1111 gives 13360/13360/6680, code 4'b1100 gives 6680/10020/6680, code 4'b0000 gives 8330/12500/8330).
- R7: In every plan, pci_f_o is mid_f_o divided by 2 and apic_f_o is mid_f_o divided by 4, each rounded down.
- R8: If code 4'b1110 is captured, reserved_o is 1, plan_idx_o is 4'b1101 and the frequencies are those of code 4'b1101. For any other code, reserved_o is 0 and plan_idx_o equals the code.
- R9: A new power-on reset restarts the timer and clears the outputs. The next capture takes the strap values present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| strap_fs_i | input | 4 | Frequency-select straps, bits 0 to 3 |
| strap_rate_i | input | 1 | Peripheral clock rate strap |
| pin_oe_o | output | 5 | Output enables for the dual-purpose pins |
| captured_o | output | 1 | Straps have been latched |
| fs_latched_o | output | 4 | Latched select code |
| rate_24m_o | output | 1 | 1 selects 24 MHz, 0 selects 48 MHz |
| plan_idx_o | output | 4 | Effective plan index after fallback |
| reserved_o | output | 1 | Reserved code was captured |
| cpu_f_o | output | 16 | CPU clock target, 10 kHz units |
| mem_f_o | output | 16 | Memory clock target, 10 kHz units |
| mid_f_o | output | 16 | Mid-rate clock target, 10 kHz units |
| pci_f_o | output | 16 | PCI clock target, 10 kHz units |
| apic_f_o | output | 16 | APIC clock target, 10 kHz units |

## Verification
The hardest condition to create from the ports is a strap change just around the end of the power-up window. The bench must show that values changed after capture never reach the outputs. It must also show that the enables wait exactly one further edge. Each table row therefore goes through a full reset, a timed wait and an edge-accurate sample on both sides of the capture edge. Directed tests then toggle the straps right after capture and apply a second power-on reset with different straps.

// File: rtl/strap_pkg.sv
package strap_pkg;
   localparam int FS_W      = 4;
   localparam int FREQ_W    = 16;
   localparam logic [FS_W-1:0] RSVD_CODE     = 4'b1110;
   localparam logic [FS_W-1:0] FALLBACK_CODE = 4'b1101;

   typedef struct packed {
      logic [FREQ_W-1:0] cpu;
      logic [FREQ_W-1:0] mem;
      logic [FREQ_W-1:0] mid;
   } base_plan_t;

   function automatic base_plan_t base_lookup(input logic [FS_W-1:0] code);
      base_plan_t p;
      unique case (code)
         4'hF: p = '{16'd13360, 16'd13360, 16'd6680};
         4'hD: p = '{16'd10020, 16'd10020, 16'd6680};
         4'hC: p = '{16'd6680,  16'd10020, 16'd6680};
         4'hB: p = '{16'd10500, 16'd10500, 16'd7000};
         4'hA: p = '{16'd11000, 16'd11000, 16'd7330};
         4'h9: p = '{16'd11400, 16'd11400, 16'd7600};
         4'h8: p = '{16'd11900, 16'd11900, 16'd7930};
         4'h7: p = '{16'd12400, 16'd12400, 16'd8270};
         4'h6: p = '{16'd12900, 16'd12900, 16'd6450};
         4'h5: p = '{16'd9500,  16'd9500,  16'd6330};
         4'h4: p = '{16'd13800, 16'd13800, 16'd6900};
         4'h3: p = '{16'd15000, 16'd15000, 16'd7500};
         4'h2: p = '{16'd7500,  16'd11300, 16'd7500};
         4'h1: p = '{16'd9000,  16'd9000,  16'd6000};
         4'h0: p = '{16'd8330,  16'd12500, 16'd8330};
         default: p = '{16'd10020, 16'd10020, 16'd6680};
      endcase
      return p;
   endfunction
endpackage

// File: rtl/por_timer.sv
module por_timer #(
   parameter int TERM_CYCLES = 28636
) (
   input  logic clk,
   input  logic rst_n,
   output logic expire_o,
   output logic done_o
);
   localparam int CW = $clog2(TERM_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(TERM_CYCLES - 1);

   if (TERM_CYCLES < 2) begin : g_bad_term
      $error("por_timer: TERM_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign expire_o = (cnt_q == LAST) && !done_q;
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (expire_o) done_q <= 1'b1;
      end
   end

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(TERM_CYCLES)); // R2
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q); // R2
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
   parameter int W           = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins_i,
   input  logic         capture_i,
   output logic [W-1:0] held_o
);
   if (W < 1) begin : g_bad_w
      $error("strap_latch: W must be positive");
   end

   logic [W-1:0] synced;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = pins_i;
   end else begin : g_sync
      logic [W-1:0] stage_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= pins_i;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
         end
      end
      assign synced = stage_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_o <= '0;
      else if (capture_i) held_o <= synced;
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(held_o)); // R3
endmodule

// File: rtl/plan_decode.sv
module plan_decode
   import strap_pkg::*;
(
   input  logic [FS_W-1:0]   code_i,
   output logic [FS_W-1:0]   idx_o,
   output logic              rsvd_o,
   output logic [FREQ_W-1:0] cpu_o,
   output logic [FREQ_W-1:0] mem_o,
   output logic [FREQ_W-1:0] mid_o,
   output logic [FREQ_W-1:0] pci_o,
   output logic [FREQ_W-1:0] apic_o
);
   base_plan_t bp;

   always_comb begin
      rsvd_o = (code_i == RSVD_CODE);
      idx_o  = rsvd_o ? FALLBACK_CODE : code_i;
      bp     = base_lookup(idx_o);
      cpu_o  = bp.cpu;
      mem_o  = bp.mem;
      mid_o  = bp.mid;
      pci_o  = bp.mid >> 1;
      apic_o = bp.mid >> 2;
   end
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
   import strap_pkg::*;
#(
   parameter int TERM_CYCLES = 28636,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic [3:0]        strap_fs_i,
   input  logic              strap_rate_i,
   output logic [4:0]        pin_oe_o,
   output logic              captured_o,
   output logic [3:0]        fs_latched_o,
   output logic              rate_24m_o,
   output logic [3:0]        plan_idx_o,
   output logic              reserved_o,
   output logic [15:0]       cpu_f_o,
   output logic [15:0]       mem_f_o,
   output logic [15:0]       mid_f_o,
   output logic [15:0]       pci_f_o,
   output logic [15:0]       apic_f_o
);
   localparam int NPINS = FS_W + 1;

   logic             expire, done;
   logic [NPINS-1:0] held;
   logic [FS_W-1:0]  idx;
   logic             rsvd;
   logic [FREQ_W-1:0] cpu, mem, mid, pci, apic;

   por_timer #(.TERM_CYCLES(TERM_CYCLES)) u_timer (
      .clk(clk_ref), .rst_n(rst_n), .expire_o(expire), .done_o(done));

   strap_latch #(.W(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk(clk_ref), .rst_n(rst_n), .pins_i({strap_rate_i, strap_fs_i}),
      .capture_i(expire), .held_o(held));

   plan_decode u_dec (
      .code_i(held[FS_W-1:0]), .idx_o(idx), .rsvd_o(rsvd),
      .cpu_o(cpu), .mem_o(mem), .mid_o(mid), .pci_o(pci), .apic_o(apic));

   for (genvar g = 0; g < NPINS; g++) begin : g_oe
      logic oe_q;
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) oe_q <= 1'b0;
         else        oe_q <= done;
      end
      assign pin_oe_o[g] = oe_q;
   end

   assign captured_o   = done;
   assign fs_latched_o = held[FS_W-1:0];
   assign rate_24m_o   = held[FS_W];
   assign plan_idx_o   = done ? idx  : '0;
   assign reserved_o   = done & rsvd;
   assign cpu_f_o      = done ? cpu  : '0;
   assign mem_f_o      = done ? mem  : '0;
   assign mid_f_o      = done ? mid  : '0;
   assign pci_f_o      = done ? pci  : '0;
   assign apic_f_o     = done ? apic : '0;

   AST_OE_UNIFORM: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (pin_oe_o == '0) || (&pin_oe_o)); // R4
   AST_OE_AFTER_CAPTURE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(pin_oe_o[0]) |-> $past(captured_o)); // R4
   AST_NO_OE_EARLY: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !captured_o |-> (pin_oe_o == '0)); // R4
   AST_ZERO_BEFORE_CAPTURE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !captured_o |-> (cpu_f_o == '0 && plan_idx_o == '0)); // R1
   AST_RSVD_FALLBACK: assert property (@(posedge clk_ref) disable iff (!rst_n)
      reserved_o |-> (plan_idx_o == FALLBACK_CODE && fs_latched_o == RSVD_CODE)); // R8
   AST_PLAN_STABLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      captured_o && $past(captured_o) |-> $stable(cpu_f_o) && $stable(rate_24m_o)); // R3
endmodule

// File: tb/strap_capture_ctrl_tb.sv
module strap_capture_ctrl_tb;
   localparam int TERM = 20;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  fs = 4'h0;
   logic        rate = 1'b0;
   logic [4:0]  oe;
   logic        cap;
   logic [3:0]  fsl;
   logic        r24;
   logic [3:0]  idx;
   logic        rsvd;
   logic [15:0] cpu, mem, mid, pci, apic;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   strap_capture_ctrl #(.TERM_CYCLES(TERM), .SYNC_STAGES(SYNC)) u_dut (
      .clk_ref(clk), .rst_n(rst_n), .strap_fs_i(fs), .strap_rate_i(rate),
      .pin_oe_o(oe), .captured_o(cap), .fs_latched_o(fsl), .rate_24m_o(r24),
      .plan_idx_o(idx), .reserved_o(rsvd), .cpu_f_o(cpu), .mem_f_o(mem),
      .mid_f_o(mid), .pci_f_o(pci), .apic_f_o(apic));

   // code, cpu, mem, mid (10 kHz units)
   localparam logic [51:0] VEC [16] = '{
      {4'hF, 16'd13360, 16'd13360, 16'd6680},
      {4'hE, 16'd10020, 16'd10020, 16'd6680},
      {4'hD, 16'd10020, 16'd10020, 16'd6680},
      {4'hC, 16'd6680,  16'd10020, 16'd6680},
      {4'hB, 16'd10500, 16'd10500, 16'd7000},
      {4'hA, 16'd11000, 16'd11000, 16'd7330},
      {4'h9, 16'd11400, 16'd11400, 16'd7600},
      {4'h8, 16'd11900, 16'd11900, 16'd7930},
      {4'h7, 16'd12400, 16'd12400, 16'd8270},
      {4'h6, 16'd12900, 16'd12900, 16'd6450},
      {4'h5, 16'd9500,  16'd9500,  16'd6330},
      {4'h4, 16'd13800, 16'd13800, 16'd6900},
      {4'h3, 16'd15000, 16'd15000, 16'd7500},
      {4'h2, 16'd7500,  16'd11300, 16'd7500},
      {4'h1, 16'd9000,  16'd9000,  16'd6000},
      {4'h0, 16'd8330,  16'd12500, 16'd8330}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reset, then sample both sides of the capture edge (R2, R4).
   task automatic por(input logic [3:0] f, input logic r);
      @(negedge clk);
      fs = f; rate = r; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cap == 1'b0 && oe == 5'd0 && cpu == 16'd0, "R1", {cap, oe}, 0);
      rst_n = 1'b1;
      repeat (TERM - 1) @(negedge clk);
      chk(cap == 1'b0, "R2", cap, 0);
      chk(oe == 5'd0 && idx == 4'd0 && apic == 16'd0, "R1", oe, 0);
      @(negedge clk);
      chk(cap == 1'b1, "R2", cap, 1);
      chk(oe == 5'd0, "R4", oe, 0);
      @(negedge clk);
      chk(oe == 5'h1F, "R4", oe, 5'h1F);
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(cap == 1'b0 && oe == 5'd0 && fsl == 4'd0 && r24 == 1'b0 && rsvd == 1'b0,
          "R1", {cap, oe, fsl}, 0);

      for (int i = 0; i < 16; i++) begin
         logic [3:0]  c;
         logic [15:0] ecpu, emem, emid;
         logic        er;
         {c, ecpu, emem, emid} = VEC[i];
         er = c[0] ^ c[3];
         por(c, er);
         chk(fsl == c, "R3", fsl, c);
         chk(r24 == er, "R5", r24, er);
         chk(cpu == ecpu && mem == emem && mid == emid, "R6", cpu, ecpu);
         chk(pci == emid / 2 && apic == emid / 4, "R7", apic, emid / 4);
         if (c == 4'hE) chk(rsvd == 1'b1 && idx == 4'hD, "R8", {rsvd, idx}, 5'h1D);
         else           chk(rsvd == 1'b0 && idx == c, "R8", {rsvd, idx}, {1'b0, c});
      end

      // R3: straps toggle after capture, outputs hold
      por(4'hF, 1'b1);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         fs = 4'(k); rate = k[0];
      end
      repeat (4) @(negedge clk);
      chk(fsl == 4'hF && r24 == 1'b1 && cpu == 16'd13360, "R3", cpu, 13360);
      chk(oe == 5'h1F, "R4", oe, 5'h1F);

      // R5: rate LOW gives 48 MHz select
      por(4'hC, 1'b0);
      chk(r24 == 1'b0, "R5", r24, 0);
      chk(cpu == 16'd6680 && mem == 16'd10020, "R6", mem, 10020);

      // R9: second power-on reset with new straps recaptures
      por(4'h2, 1'b1);
      chk(fsl == 4'h2 && r24 == 1'b1 && mem == 16'd11300, "R9", mem, 11300);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule